// File: doc/BRIEF.md
# Program Counter and Return Stack Unit

This unit produces the instruction fetch address for a small microcontroller core. It holds a 13-bit program counter, which gives an 8K-word logical space. Only the low 2K words are backed by program memory, so the fetch address is the low 11 bits of the counter. Any address above 07FFh therefore folds back into the implemented space without extra logic.

Each cycle the decoder issues one encoded command on `cmd`. The unit can hold, step, jump, call, return, return from interrupt, return with a literal, or take an interrupt. Calls and interrupts save the address that follows the current one on an 8-entry circular return stack. The three return forms take an address back from that stack. Return-from-interrupt also pulses an interrupt-enable strobe for one cycle. Return-with-literal hands its 8-bit literal to the working-register interface for one cycle.

All results are registered. The counter and the side outputs change on the clock edge that samples the command.

Top module: `pc_stack_unit`

## Requirements
- R1: While `rstN` is low, `pc` is 0000h and `gieSet`, `wValid` and `wData` are zero.
- R2: Command 1 (step) loads `pc+1`. The counter is 13 bits wide, so 1FFFh steps to 0000h.
- R3: Command 2 (jump) loads `target` into `pc`.
- R4: Command 3 (call) pushes `pc+1` onto the return stack and loads `target`.
- R5: Command 7 (interrupt) pushes `pc+1` onto the return stack and loads 0004h.
- R6: Command 4 (return) loads the most recently pushed address and removes it from the stack.
- R7: The stack has 8 circular slots. A ninth push overwrites the oldest entry. A pop on an empty stack wraps the pointer and returns whatever that slot holds, and no error is raised.
- R8: Command 5 (return from interrupt) pops like R6 and drives `gieSet` high for exactly the following cycle. `gieSet` is low after any other command.
- R9: Command 6 (return with literal) pops like R6. For the following cycle it drives `wValid` high and `wData` equal to `literal`. After any other command, `wValid` and `wData` are zero.
- R10: `fetchAddr` always equals `pc[10:0]`.
- R11: Command 0 (hold) leaves `pc` and the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmd | input | 3 | Encoded command for this cycle |
| target | input | 13 | Destination for jump and call |
| literal | input | 8 | Literal carried by return-with-literal |
| pc | output | 13 | Current program counter |
| fetchAddr | output | 11 | Address into implemented program memory |
| gieSet | output | 1 | One-cycle interrupt-enable strobe |
| wValid | output | 1 | Literal handoff valid |
| wData | output | 8 | Literal for the working register |

## Verification
The bench goes after several corner cases.

- **Counter wrap at 1FFFh.** A counter cut short to 11 bits, or one that saturates, would show up here.
- **High jump target.** A jump above 07FFh checks the fold of the fetch address. A design that clipped the address instead of dropping the high bits would fetch the wrong word.
- **Nine nested calls followed by nine returns.** This exercises stack overwrite and the pop past empty. An off-by-one pointer or a stack that saturates would return the wrong address.
- **Interrupt followed by return-from-interrupt.** A stack that pushed the current address instead of the next one would re-run an instruction. A strobe that stayed high would show up as a second asserted cycle.

Random command mixes then look for stale literals and unexpected strobes.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [2:0] {
    CMD_HOLD   = 3'd0,
    CMD_STEP   = 3'd1,
    CMD_JUMP   = 3'd2,
    CMD_CALL   = 3'd3,
    CMD_RET    = 3'd4,
    CMD_RETIE  = 3'd5,
    CMD_RETLIT = 3'd6,
    CMD_IRQ    = 3'd7
  } pcCmdE;

  // strobes from control to datapath
  typedef struct packed {
    logic incr;    // load pc+1
    logic load;    // load external target
    logic vector;  // load interrupt vector
    logic push;    // save pc+1 on stack
    logic pop;     // restore pc from stack
  } pcStrobeT;

endpackage

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
#(
  parameter int unsigned LIT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cmd,
  input  logic [LIT_W-1:0] literal,
  output pcStrobeT         strobes,
  output logic             gieSet,
  output logic             wValid,
  output logic [LIT_W-1:0] wData
);

  pcCmdE cmdE;
  assign cmdE = pcCmdE'(cmd);

  always_comb begin
    strobes = '0;
    unique case (cmdE)
      CMD_HOLD:   ;
      CMD_STEP:   strobes.incr = 1'b1;
      CMD_JUMP:   strobes.load = 1'b1;
      CMD_CALL:   begin strobes.load = 1'b1;   strobes.push = 1'b1; end
      CMD_IRQ:    begin strobes.vector = 1'b1; strobes.push = 1'b1; end
      CMD_RET,
      CMD_RETIE,
      CMD_RETLIT: strobes.pop = 1'b1;
      default:    ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gieSet <= 1'b0;
      wValid <= 1'b0;
      wData  <= '0;
    end else begin
      gieSet <= (cmdE == CMD_RETIE);
      wValid <= (cmdE == CMD_RETLIT);
      wData  <= (cmdE == CMD_RETLIT) ? literal : '0;
    end
  end

  // R8
  gie_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdE != CMD_RETIE) |=> !gieSet);

  // R9
  lit_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdE != CMD_RETLIT) |=> (!wValid && wData == '0));

  // R8
  retie_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdE == CMD_RETIE) |-> (strobes.pop && !strobes.push));

endmodule

// File: rtl/pcu_datapath.sv
module pcu_datapath
  import pcu_pkg::*;
#(
  parameter int unsigned PC_W      = 13,
  parameter int unsigned IMPL_W    = 11,
  parameter int unsigned DEPTH     = 8,
  parameter logic [PC_W-1:0] RESET_VEC = '0,
  parameter logic [PC_W-1:0] IRQ_VEC   = PC_W'(4)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcStrobeT          strobes,
  input  logic [PC_W-1:0]   target,
  output logic [PC_W-1:0]   pcQ,
  output logic [IMPL_W-1:0] fetchAddr
);

  localparam int unsigned SP_W = $clog2(DEPTH);

  logic [PC_W-1:0] slot [DEPTH];
  logic [SP_W-1:0] sp;       // next free slot
  logic [SP_W-1:0] topIdx;
  logic [PC_W-1:0] pcPlus1;
  logic [PC_W-1:0] pcNext;

  assign pcPlus1   = pcQ + 1'b1;
  assign topIdx    = sp - 1'b1;
  assign fetchAddr = pcQ[IMPL_W-1:0];

  always_comb begin
    if (strobes.pop)         pcNext = slot[topIdx];
    else if (strobes.vector) pcNext = IRQ_VEC;
    else if (strobes.load)   pcNext = target;
    else if (strobes.incr)   pcNext = pcPlus1;
    else                     pcNext = pcQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcQ <= RESET_VEC;
    else       pcQ <= pcNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp <= '0;
      for (int i = 0; i < int'(DEPTH); i++) slot[i] <= '0;
    end else if (strobes.push) begin
      slot[sp] <= pcPlus1;
      sp       <= sp + 1'b1;
    end else if (strobes.pop) begin
      sp <= topIdx;
    end
  end

  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == pcStrobeT'(5'b10000)) |=> (pcQ == $past(pcQ) + 1'b1));

  // R5
  vec_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.vector |=> (pcQ == IRQ_VEC));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0) |=> ($stable(pcQ) && $stable(sp)));

  // R7
  push_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.push |=> (sp == $past(sp) + 1'b1));

  // R6
  pop_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pop && !strobes.push) |=> (sp == $past(sp) - 1'b1));

endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
  import pcu_pkg::*;
#(
  parameter int unsigned PC_W   = 13,
  parameter int unsigned IMPL_W = 11,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned LIT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmd,
  input  logic [PC_W-1:0]   target,
  input  logic [LIT_W-1:0]  literal,
  output logic [PC_W-1:0]   pc,
  output logic [IMPL_W-1:0] fetchAddr,
  output logic              gieSet,
  output logic              wValid,
  output logic [LIT_W-1:0]  wData
);

  pcStrobeT strobes;

  pcu_ctrl #(.LIT_W(LIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmd(cmd), .literal(literal),
    .strobes(strobes), .gieSet(gieSet), .wValid(wValid), .wData(wData)
  );

  pcu_datapath #(.PC_W(PC_W), .IMPL_W(IMPL_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .target(target),
    .pcQ(pc), .fetchAddr(fetchAddr)
  );

endmodule

// File: tb/pc_stack_unit_test.sv
`timescale 1ns/1ps
module pc_stack_unit_test;
  import pcu_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN;
  logic [2:0]  cmd;
  logic [12:0] target;
  logic [7:0]  literal;
  logic [12:0] pc;
  logic [10:0] fetchAddr;
  logic        gieSet, wValid;
  logic [7:0]  wData;

  pc_stack_unit uut (
    .clk(clk), .rstN(rstN), .cmd(cmd), .target(target), .literal(literal),
    .pc(pc), .fetchAddr(fetchAddr), .gieSet(gieSet), .wValid(wValid), .wData(wData)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [12:0] mPc;
  logic [12:0] mStk [8];
  logic [2:0]  mSp;
  logic        mGie, mWv;
  logic [7:0]  mWd;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(logic [2:0] c);
    case (c)
      3'd0: return "R11";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R6";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R5";
    endcase
  endfunction

  task automatic checkAll(string req);
    check(req,   "pc",        32'(pc),        32'(mPc));
    check("R10", "fetchAddr", 32'(fetchAddr), 32'(mPc[10:0]));
    check("R8",  "gieSet",    32'(gieSet),    32'(mGie));
    check("R9",  "wValid",    32'(wValid),    32'(mWv));
    check("R9",  "wData",     32'(wData),     32'(mWd));
  endtask

  // drive at a falling edge, update the model, check at the next falling edge
  task automatic apply(logic [2:0] c, logic [12:0] t, logic [7:0] l, string req);
    cmd = c; target = t; literal = l;
    mGie = (c == 3'd5);
    mWv  = (c == 3'd6);
    mWd  = (c == 3'd6) ? l : 8'h00;
    case (c)
      3'd1: mPc = mPc + 13'd1;
      3'd2: mPc = t;
      3'd3: begin mStk[mSp] = mPc + 13'd1; mSp = mSp + 3'd1; mPc = t; end
      3'd7: begin mStk[mSp] = mPc + 13'd1; mSp = mSp + 3'd1; mPc = 13'h0004; end
      3'd4, 3'd5, 3'd6: begin mSp = mSp - 3'd1; mPc = mStk[mSp]; end
      default: ;
    endcase
    @(negedge clk);
    checkAll(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd715));
    rstN = 1'b0; cmd = 3'd0; target = '0; literal = '0;
    mPc = '0; mSp = '0; mGie = 0; mWv = 0; mWd = '0;
    for (int i = 0; i < 8; i++) mStk[i] = '0;
    repeat (3) @(negedge clk);
    checkAll("R1");
    rstN = 1'b1;

    apply(3'd0, 13'h1234, 8'h00, "R11");
    repeat (3) apply(3'd1, 13'h0, 8'h0, "R2");
    apply(3'd2, 13'h1FFE, 8'h0, "R3");
    apply(3'd1, 13'h0, 8'h0, "R2");
    apply(3'd1, 13'h0, 8'h0, "R2");          // 1FFF -> 0000
    apply(3'd2, 13'h0ABC, 8'h0, "R10");      // folds to 2BC
    apply(3'd0, 13'h0555, 8'h77, "R11");
    apply(3'd0, 13'h0666, 8'h77, "R11");
    apply(3'd3, 13'h0100, 8'h0, "R4");
    apply(3'd7, 13'h0999, 8'h0, "R5");
    apply(3'd5, 13'h0, 8'h0, "R8");          // back to 0x101
    apply(3'd0, 13'h0, 8'h0, "R8");          // strobe dropped
    apply(3'd6, 13'h0, 8'hA5, "R9");         // back to 0xABD
    apply(3'd1, 13'h0, 8'h3C, "R9");         // literal cleared
    apply(3'd4, 13'h0, 8'h0, "R7");          // pop on empty stack wraps

    // nine nested calls overflow the 8-entry stack, then nine returns
    for (int i = 0; i < 9; i++) apply(3'd3, 13'(13'h0200 + i * 16), 8'h0, "R7");
    for (int i = 0; i < 9; i++) apply(3'd4, 13'h0, 8'h0, "R7");

    for (int n = 0; n < 3000; n++)
      begin
        logic [2:0] c;
        c = 3'($urandom_range(0, 7));
        apply(c, 13'($urandom), 8'($urandom), reqOf(c));
      end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule